// File: doc/BRIEF.md
# Indexed Control Register Access Unit

This block gives one serial channel a set of extended control registers that sit behind a small byte-wide bus with eight addresses and a 3-bit address. The bus has only a few free addresses, so the extended registers are reached indirectly. Software first writes an offset into the scratch register at address 111b. It then uses the data window at address 101b to write, or read back, the extended register that the offset selects.

The extended set has three writable registers. The first is a control register at offset 0x00, whose bit 6 unlocks reads through the window. The second is the nine-bit mode register at offset 0x0D. The third is a clock alteration register at offset 0x13. There are also four read-only bytes: the identification bytes at offsets 0x08 to 0x0A and a core revision byte at offset 0x0B. A write through the window always lands in the indexed register. A read through the window returns the indexed value only while the unlock bit is set; otherwise it returns the standard register that normally lives at 101b. The block gets that standard value, and the value of every other address it does not own, from the surrounding register bank on `std_rdata`.

Read data is registered. A read issued in one cycle shows on `bus_rdata` after the next rising edge and stays there until the next read.

Top module: `icr_access_unit`

## Requirements
- R1: After reset, the offset, the control register, the nine-bit mode register, the clock alteration register and `bus_rdata` are all 0x00.
- R2: A write at address 111b stores the byte as the offset, and a later read at 111b returns it.
- R3: A write at address 101b stores the byte in the register the offset selects: 0x00 is the control register, 0x0D the nine-bit mode register, 0x13 the clock alteration register. The new value shows on the matching output after that write edge, whatever control bit 6 holds.
- R4: With control register bit 6 at 1, a read at 101b returns the register the current offset selects.
- R5: With control register bit 6 at 0, a read at 101b returns `std_rdata` as sampled at the read edge.
- R6: With bit 6 at 1, offsets 0x08, 0x09 and 0x0A read 0x16, 0xC9 and 0x54, and offset 0x0B reads the REV_ID parameter (default 0x01).
- R7: A window write to a read-only or undefined offset changes no writable register and no read-only byte.
- R8: With bit 6 at 1, a read of any offset other than 0x00, 0x08 to 0x0B, 0x0D and 0x13 returns 0x00.
- R9: `nine_bit_en` equals bit 0 of the nine-bit mode register.
- R10: A read at any address other than 101b and 111b returns `std_rdata`.
- R11: `bus_rdata` changes only on the edge after a cycle with `bus_rd` high, and holds its value otherwise.
- R12: Clearing control bit 6 through the window makes later reads at 101b return `std_rdata` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| std_rdata | input | 8 | Read value of the standard register bank for the current address |
| bus_rdata | output | 8 | Registered read data |
| ext_ctrl | output | 8 | Extended control register (offset 0x00) |
| nine_bit_mode | output | 8 | Nine-bit mode register (offset 0x0D) |
| clk_alter | output | 8 | Clock alteration register (offset 0x13) |
| nine_bit_en | output | 1 | Nine-bit framing enable |

## Verification
A wrong offset register sends the next window write to the wrong place. That error shows on one of the three register outputs on the edge right after that write, and on the next read at 111b. A wrong unlock state shows up on the first read at 101b: the bench holds `std_rdata` at a value that no indexed register contains, so a read that takes the wrong source is caught the cycle after the read strobe. A read-data register that is not held correctly shows up during idle cycles while `std_rdata` is made to change.

// File: rtl/icr_pkg.sv
package icr_pkg;

  // Offsets inside the indexed space
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_ID_A  = 8'h08;
  localparam logic [7:0] OFS_ID_B  = 8'h09;
  localparam logic [7:0] OFS_ID_C  = 8'h0A;
  localparam logic [7:0] OFS_REV   = 8'h0B;
  localparam logic [7:0] OFS_NINE  = 8'h0D;
  localparam logic [7:0] OFS_CLKA  = 8'h13;

  // Fixed identification bytes
  localparam logic [7:0] ID_A_VAL  = 8'h16;
  localparam logic [7:0] ID_B_VAL  = 8'h C9;
  localparam logic [7:0] ID_C_VAL  = 8'h54;

  // Writable slots, in slot order
  localparam int unsigned NUM_WR_SLOTS = 3;
  typedef enum int unsigned {
    SLOT_CTRL = 0,
    SLOT_NINE = 1,
    SLOT_CLKA = 2
  } wr_slot_e;

  function automatic logic [7:0] slot_offset(input int unsigned slot);
    case (slot)
      SLOT_CTRL: slot_offset = OFS_CTRL;
      SLOT_NINE: slot_offset = OFS_NINE;
      default:   slot_offset = OFS_CLKA;
    endcase
  endfunction

  // Bit positions with a function
  localparam int unsigned CTRL_RDEN_BIT = 6;
  localparam int unsigned NINE_EN_BIT   = 0;

  // Address decode result
  typedef enum logic [1:0] {
    SEL_OTHER = 2'd0,
    SEL_WIN   = 2'd1,
    SEL_OFS   = 2'd2
  } bus_sel_e;

endpackage

// File: rtl/icr_rst_sync.sv
module icr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[LAST];

endmodule

// File: rtl/icr_bus_decode.sv
module icr_bus_decode
  import icr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 3'b101,
  parameter logic [ADDR_W-1:0] OFS_ADDR = 3'b111
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output bus_sel_e          sel,
  output logic              ofs_we,
  output logic              win_we,
  output logic              rd_fire
);

  always_comb begin
    if (bus_addr == OFS_ADDR) begin
      sel = SEL_OFS;
    end else if (bus_addr == WIN_ADDR) begin
      sel = SEL_WIN;
    end else begin
      sel = SEL_OTHER;
    end
  end

  always_comb begin
    ofs_we  = bus_wr && (sel == SEL_OFS);
    win_we  = bus_wr && (sel == SEL_WIN);
    rd_fire = bus_rd;
  end

endmodule

// File: rtl/icr_regfile.sv
module icr_regfile
  import icr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_WR = NUM_WR_SLOTS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ofs_we,
  input  logic                           win_we,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              offset_q,
  output logic [NUM_WR-1:0][DATA_W-1:0]  slot_q
);

  logic [DATA_W-1:0] offset_d;

  // Offset register: next state, then storage
  always_comb begin
    offset_d = offset_q;
    if (ofs_we) begin
      offset_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
    end else begin
      offset_q <= offset_d;
    end
  end

  // One storage slot per writable indexed register
  for (genvar g = 0; g < NUM_WR; g++) begin : g_slot
    localparam logic [DATA_W-1:0] SLOT_OFS = DATA_W'(slot_offset(g));

    logic              hit;
    logic [DATA_W-1:0] slot_d;

    always_comb begin
      hit    = win_we && (offset_q == SLOT_OFS);
      slot_d = slot_q[g];
      if (hit) begin
        slot_d = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else begin
        slot_q[g] <= slot_d;
      end
    end
  end

endmodule

// File: rtl/icr_read_mux.sv
module icr_read_mux
  import icr_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter int unsigned       NUM_WR = NUM_WR_SLOTS,
  parameter logic [DATA_W-1:0] REV_ID = 8'h01
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  bus_sel_e                      sel,
  input  logic                          rd_fire,
  input  logic [DATA_W-1:0]             offset_q,
  input  logic [NUM_WR-1:0][DATA_W-1:0] slot_q,
  input  logic [DATA_W-1:0]             std_rdata,
  output logic [DATA_W-1:0]             rdata_q
);

  logic [DATA_W-1:0] win_val;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_d;
  logic              rd_unlock;

  // Value of the indexed register selected by the offset
  always_comb begin
    case (offset_q)
      DATA_W'(OFS_CTRL): win_val = slot_q[SLOT_CTRL];
      DATA_W'(OFS_ID_A): win_val = DATA_W'(ID_A_VAL);
      DATA_W'(OFS_ID_B): win_val = DATA_W'(ID_B_VAL);
      DATA_W'(OFS_ID_C): win_val = DATA_W'(ID_C_VAL);
      DATA_W'(OFS_REV):  win_val = REV_ID;
      DATA_W'(OFS_NINE): win_val = slot_q[SLOT_NINE];
      DATA_W'(OFS_CLKA): win_val = slot_q[SLOT_CLKA];
      default:           win_val = '0;
    endcase
  end

  always_comb begin
    rd_unlock = slot_q[SLOT_CTRL][CTRL_RDEN_BIT];
    case (sel)
      SEL_OFS: rd_next = offset_q;
      SEL_WIN: rd_next = rd_unlock ? win_val : std_rdata;
      default: rd_next = std_rdata;
    endcase
    rdata_d = rd_fire ? rd_next : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/icr_access_unit.sv
module icr_access_unit
  import icr_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 3,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 3'b101,
  parameter logic [ADDR_W-1:0] OFS_ADDR = 3'b111,
  parameter logic [DATA_W-1:0] REV_ID   = 8'h01,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] std_rdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ext_ctrl,
  output logic [DATA_W-1:0] nine_bit_mode,
  output logic [DATA_W-1:0] clk_alter,
  output logic              nine_bit_en
);

  localparam int unsigned NUM_WR = NUM_WR_SLOTS;

  logic                          rst_core_n;
  bus_sel_e                      sel;
  logic                          ofs_we;
  logic                          win_we;
  logic                          rd_fire;
  logic [DATA_W-1:0]             idx_offset;
  logic [NUM_WR-1:0][DATA_W-1:0] slot_q;

  icr_rst_sync #(
    .STAGES (RST_STAGES)
  ) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  icr_bus_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_ADDR (WIN_ADDR),
    .OFS_ADDR (OFS_ADDR)
  ) i_decode (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .sel      (sel),
    .ofs_we   (ofs_we),
    .win_we   (win_we),
    .rd_fire  (rd_fire)
  );

  icr_regfile #(
    .DATA_W (DATA_W),
    .NUM_WR (NUM_WR)
  ) i_regfile (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ofs_we   (ofs_we),
    .win_we   (win_we),
    .wdata    (bus_wdata),
    .offset_q (idx_offset),
    .slot_q   (slot_q)
  );

  icr_read_mux #(
    .DATA_W (DATA_W),
    .NUM_WR (NUM_WR),
    .REV_ID (REV_ID)
  ) i_read_mux (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sel       (sel),
    .rd_fire   (rd_fire),
    .offset_q  (idx_offset),
    .slot_q    (slot_q),
    .std_rdata (std_rdata),
    .rdata_q   (bus_rdata)
  );

  assign ext_ctrl      = slot_q[SLOT_CTRL];
  assign nine_bit_mode = slot_q[SLOT_NINE];
  assign clk_alter     = slot_q[SLOT_CLKA];
  assign nine_bit_en   = slot_q[SLOT_NINE][NINE_EN_BIT];

endmodule

// File: rtl/icr_access_chk.sv
module icr_access_chk #(
  parameter int unsigned       ADDR_W   = 3,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 3'b101,
  parameter logic [ADDR_W-1:0] OFS_ADDR = 3'b111
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] std_rdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ext_ctrl,
  input logic [DATA_W-1:0] nine_bit_mode,
  input logic [DATA_W-1:0] clk_alter,
  input logic [DATA_W-1:0] offset
);

  logic writable_ofs;
  assign writable_ofs = (offset == DATA_W'(8'h00)) || (offset == DATA_W'(8'h0D)) ||
                        (offset == DATA_W'(8'h13));

  // R2
  ofs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ADDR) |=> (offset == $past(bus_wdata)));

  // R3
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WIN_ADDR && offset == DATA_W'(8'h00))
      |=> (ext_ctrl == $past(bus_wdata)));

  // R3
  clka_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WIN_ADDR && offset == DATA_W'(8'h13))
      |=> (clk_alter == $past(bus_wdata)));

  // R7
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WIN_ADDR && !writable_ofs)
      |=> ($stable(ext_ctrl) && $stable(nine_bit_mode) && $stable(clk_alter)));

  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == WIN_ADDR && !ext_ctrl[6])
      |=> (bus_rdata == $past(std_rdata)));

  // R10
  other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != WIN_ADDR && bus_addr != OFS_ADDR)
      |=> (bus_rdata == $past(std_rdata)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind icr_access_unit icr_access_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WIN_ADDR (WIN_ADDR),
  .OFS_ADDR (OFS_ADDR)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_wdata     (bus_wdata),
  .std_rdata     (std_rdata),
  .bus_rdata     (bus_rdata),
  .ext_ctrl      (ext_ctrl),
  .nine_bit_mode (nine_bit_mode),
  .clk_alter     (clk_alter),
  .offset        (idx_offset)
);

// File: tb/test_icr_access_unit.sv
module test_icr_access_unit;

  localparam logic [2:0] A_WIN = 3'b101;
  localparam logic [2:0] A_OFS = 3'b111;
  localparam logic [7:0] STD_V = 8'hA5;

  localparam logic [2:0] OP_WR   = 3'd0;
  localparam logic [2:0] OP_RD   = 3'd1;
  localparam logic [2:0] OP_CTRL = 3'd2;
  localparam logic [2:0] OP_NINE = 3'd3;
  localparam logic [2:0] OP_CLKA = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t TBL [0:NV-1] = '{
    '{OP_RD,   A_OFS, 8'h00, 8'h00, 4'd1},  // R1 offset reads zero
    '{OP_RD,   A_WIN, 8'h00, STD_V, 4'd5},  // R5 locked window
    '{OP_WR,   A_OFS, 8'h13, 8'h00, 4'd2},
    '{OP_RD,   A_OFS, 8'h00, 8'h13, 4'd2},  // R2
    '{OP_WR,   A_WIN, 8'h5A, 8'h00, 4'd3},
    '{OP_CLKA, 3'd0,  8'h00, 8'h5A, 4'd3},  // R3 write while locked
    '{OP_RD,   A_WIN, 8'h00, STD_V, 4'd5},  // R5 still locked
    '{OP_WR,   A_OFS, 8'h00, 8'h00, 4'd2},
    '{OP_WR,   A_WIN, 8'h40, 8'h00, 4'd3},
    '{OP_CTRL, 3'd0,  8'h00, 8'h40, 4'd3},  // R3 control
    '{OP_RD,   A_WIN, 8'h00, 8'h40, 4'd4},  // R4 control reads back
    '{OP_WR,   A_OFS, 8'h13, 8'h00, 4'd2},
    '{OP_RD,   A_WIN, 8'h00, 8'h5A, 4'd4},  // R4 clock alteration
    '{OP_WR,   A_OFS, 8'h08, 8'h00, 4'd2},
    '{OP_RD,   A_WIN, 8'h00, 8'h16, 4'd6},  // R6
    '{OP_WR,   A_OFS, 8'h09, 8'h00, 4'd2},
    '{OP_RD,   A_WIN, 8'h00, 8'hC9, 4'd6},  // R6
    '{OP_WR,   A_OFS, 8'h0A, 8'h00, 4'd2},
    '{OP_RD,   A_WIN, 8'h00, 8'h54, 4'd6},  // R6
    '{OP_WR,   A_OFS, 8'h0B, 8'h00, 4'd2},
    '{OP_RD,   A_WIN, 8'h00, 8'h01, 4'd6},  // R6 revision
    '{OP_WR,   A_OFS, 8'h0D, 8'h00, 4'd2},
    '{OP_WR,   A_WIN, 8'h81, 8'h00, 4'd3},
    '{OP_NINE, 3'd0,  8'h00, 8'h81, 4'd3},  // R3 nine-bit
    '{OP_RD,   A_WIN, 8'h00, 8'h81, 4'd4},  // R4
    '{OP_WR,   A_OFS, 8'h08, 8'h00, 4'd2},
    '{OP_WR,   A_WIN, 8'hFF, 8'h00, 4'd7},
    '{OP_RD,   A_WIN, 8'h00, 8'h16, 4'd7},  // R7 ID unchanged
    '{OP_CTRL, 3'd0,  8'h00, 8'h40, 4'd7},  // R7
    '{OP_NINE, 3'd0,  8'h00, 8'h81, 4'd7},  // R7
    '{OP_CLKA, 3'd0,  8'h00, 8'h5A, 4'd7},  // R7
    '{OP_WR,   A_OFS, 8'h05, 8'h00, 4'd2},
    '{OP_WR,   A_WIN, 8'h77, 8'h00, 4'd7},
    '{OP_RD,   A_WIN, 8'h00, 8'h00, 4'd8},  // R8
    '{OP_CTRL, 3'd0,  8'h00, 8'h40, 4'd7},  // R7
    '{OP_CLKA, 3'd0,  8'h00, 8'h5A, 4'd7},  // R7
    '{OP_WR,   A_OFS, 8'hFF, 8'h00, 4'd2},
    '{OP_RD,   A_WIN, 8'h00, 8'h00, 4'd8},  // R8
    '{OP_RD,   3'b000, 8'h00, STD_V, 4'd10}, // R10
    '{OP_RD,   3'b011, 8'h00, STD_V, 4'd10}, // R10
    '{OP_WR,   A_OFS, 8'h00, 8'h00, 4'd2},
    '{OP_WR,   A_WIN, 8'h00, 8'h00, 4'd12},
    '{OP_RD,   A_WIN, 8'h00, STD_V, 4'd12}, // R12 window relocked
    '{OP_CTRL, 3'd0,  8'h00, 8'h00, 4'd12}  // R12
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] std_rdata;
  logic [7:0] bus_rdata;
  logic [7:0] ext_ctrl;
  logic [7:0] nine_bit_mode;
  logic [7:0] clk_alter;
  logic       nine_bit_en;

  int n_run;
  int n_fail;

  icr_access_unit i_icr_access_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .std_rdata     (std_rdata),
    .bus_rdata     (bus_rdata),
    .ext_ctrl      (ext_ctrl),
    .nine_bit_mode (nine_bit_mode),
    .clk_alter     (clk_alter),
    .nine_bit_en   (nine_bit_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    n_run     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    std_rdata = STD_V;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    check("R1 ext_ctrl", ext_ctrl, 8'h00);
    check("R1 nine_bit_mode", nine_bit_mode, 8'h00);
    check("R1 clk_alter", clk_alter, 8'h00);
    check("R1 bus_rdata", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", TBL[i].req, i);
      case (TBL[i].op)
        OP_WR:   bus_write(TBL[i].addr, TBL[i].data);
        OP_RD:   begin bus_read(TBL[i].addr, got); check(tag, got, TBL[i].expv); end
        OP_CTRL: check(tag, ext_ctrl, TBL[i].expv);
        OP_NINE: check(tag, nine_bit_mode, TBL[i].expv);
        default: check(tag, clk_alter, TBL[i].expv);
      endcase
    end

    // R9 nine-bit enable follows bit 0
    check("R9 enable set", {7'd0, nine_bit_en}, 8'h01);
    bus_write(A_OFS, 8'h0D);
    bus_write(A_WIN, 8'hFE);
    check("R9 enable clear", {7'd0, nine_bit_en}, 8'h00);

    // R5 locked window follows a changing standard value
    std_rdata = 8'h3C;
    bus_read(A_WIN, got);
    check("R5 std 3C", got, 8'h3C);

    // R11 read data holds through idle cycles
    std_rdata = 8'hE7;
    repeat (3) @(negedge clk);
    check("R11 hold", bus_rdata, 8'h3C);
    bus_write(A_WIN, 8'h11);
    check("R11 hold over write", bus_rdata, 8'h3C);

    // R2 offset written while unlocked reads back
    bus_write(A_OFS, 8'h00);
    bus_write(A_WIN, 8'h40);
    bus_write(A_OFS, 8'h2B);
    bus_read(A_OFS, got);
    check("R2 offset 2B", got, 8'h2B);
    bus_read(A_WIN, got);
    check("R8 offset 2B", got, 8'h00);

    // R1 reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid ext_ctrl", ext_ctrl, 8'h00);
    check("R1 mid nine_bit_mode", nine_bit_mode, 8'h00);
    check("R1 mid bus_rdata", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(A_OFS, got);
    check("R1 mid offset", got, 8'h00);

    finish_run();
  end

endmodule